// File: doc/BRIEF.md
# Key-Protected Option Control Register

This block holds the control bits that govern changes to non-volatile option settings and guards them with a lock bit. A simple register bus (write enable, address, write data, combinational read data) reaches one control register, a key register and a small set of protected register windows that live elsewhere. While the lock bit is set, every bus write that could alter the option state is dropped. The control bits other than the lock bit are ignored. No write-permit strobe is given to the protected windows, which hold the one-time-programmable words, the key control register and the protection-area registers.

The lock bit is set by writing 1 to it. It is cleared only by writing two 32-bit key words, in order, to the key register. A wrong word, a second key arriving without the first, or an unlock attempt while the register is already unlocked sends the key sequencer into a lockout state that survives until reset. In that state, even the correct key pair leaves the lock set. The block also issues a one-cycle start pulse to the option programming engine when the program-options bit rises, and drives a registered interrupt built from three enable bits and three error flags.

Top module: `optctl_top`

## Requirements
- R1: After reset the control register reads 0 (lock, program-options and the three interrupt enables all 0), and `irqOut`, `progStart` and every `winWrStb` bit are 0.
- R2: While unlocked, a write to the control register (address 0) updates every field: bit 0 lock, bit 1 program-options, bit 4 key-valid-error enable, bit 5 key-transfer-error enable, bit 6 option-change-error enable. All other bits always read 0.
- R3: While the lock bit is 1, writes to the control register change no bit. A 0 written to bit 0 does not clear the lock.
- R4: `winWrStb[i]` is 1 in the same cycle as a bus write to address WIN_BASE+i, and only when the lock bit is 0. It is 0 at every other time.
- R5: While locked and not locked out, writing KEY1 and then KEY2 to the key register (address 1) clears the lock bit. The cleared bit reads back in the cycle after the KEY2 write.
- R6: Any of the following puts the sequencer into lockout: a first key word other than KEY1, a second word other than KEY2, a key write while unlocked (a repeated unlock), or KEY2 as the first word. After that, a correct KEY1/KEY2 pair leaves the lock at 1 until reset. Reset clears the lockout.
- R7: A write that sets the lock bit from 0 to 1 also updates the other fields in that same write.
- R8: `progStart` is a one-cycle pulse in the cycle after an unlocked write moves program-options from 0 to 1. No pulse is given if the bit was already 1 or if the register is locked.
- R9: `progDone` clears the program-options bit on the next clock edge, unless the same cycle holds an accepted control write, which then takes priority.
- R10: `irqOut` equals the OR of (enable AND flag) over the three error sources, as sampled on the previous clock edge.
- R11: Reads always succeed. The key register and all unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| busWe | input | 1 | Bus write enable |
| busAddr | input | ADDR_W | Bus word address |
| busWdata | input | DATA_W | Bus write data |
| busRdata | output | DATA_W | Combinational read data for busAddr |
| kvErrFlag | input | 1 | Key-valid error status flag |
| ktErrFlag | input | 1 | Key-transfer error status flag |
| optErrFlag | input | 1 | Option-change error status flag |
| progDone | input | 1 | Option programming finished; clears program-options |
| progStart | output | 1 | One-cycle start pulse to the programming engine |
| winWrStb | output | NUM_WIN | Write-permit strobes for the protected windows |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its defaults: ADDR_W 4, NUM_WIN 3 with the windows at addresses 4 to 6, and two fixed 32-bit keys. With a 16-word address space, every address except the key register can be swept for write strobes and read data in both lock states. With only three interrupt sources, all 64 enable and flag combinations can be checked against a value the bench computes. Each of the four lockout causes runs from a fresh reset, so the bench can confirm that a correct key pair is refused afterwards and accepted again after reset.

// File: rtl/optctl_pkg.sv
package optctl_pkg;

  // Control register field positions (decoded by software and by the bench)
  localparam int LOCK_POS = 0;
  localparam int PROG_POS = 1;
  localparam int KVIE_POS = 4;
  localparam int KTIE_POS = 5;
  localparam int OEIE_POS = 6;

  // Key sequencer states; KS_DEAD is the sticky lockout
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_DEAD = 2'd2
  } keyState_e;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic fieldWr;    // accepted control-register write
    logic ctrlRdSel;  // read address selects control register
    logic newProg;
    logic newKvIe;
    logic newKtIe;
    logic newOeIe;
  } ctrlStb_t;

endpackage

// File: rtl/optctl_ctrl.sv
module optctl_ctrl
  import optctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4C0F_A9E1,
  parameter logic [DATA_W-1:0] KEY2 = 32'h7B35_D206,
  parameter int CTRL_ADDR = 0,
  parameter int KEY_ADDR = 1,
  parameter int WIN_BASE = 4,
  parameter int NUM_WIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              lockBit,
  output ctrlStb_t          stb,
  output logic [NUM_WIN-1:0] winWrStb
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);

  keyState_e keyState, keyNext;
  logic ctrlSel, keySel, keyWr, ctrlWr, unlockNow, lockSetNow;

  assign ctrlSel = (busAddr == CTRL_A);
  assign keySel  = (busAddr == KEY_A);
  assign keyWr   = busWe && keySel;
  assign ctrlWr  = busWe && ctrlSel;

  // Key sequencer next state
  always_comb begin
    keyNext   = keyState;
    unlockNow = 1'b0;
    if (keyWr) begin
      unique case (keyState)
        KS_IDLE: begin
          if (!lockBit)               keyNext = KS_DEAD;  // repeated unlock
          else if (busWdata == KEY1)  keyNext = KS_HALF;
          else                        keyNext = KS_DEAD;
        end
        KS_HALF: begin
          if (busWdata == KEY2) begin
            keyNext   = KS_IDLE;
            unlockNow = 1'b1;
          end else begin
            keyNext = KS_DEAD;
          end
        end
        default: keyNext = KS_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KS_IDLE;
    else       keyState <= keyNext;
  end

  // Lock bit: set by an unlocked write of 1, cleared only by the key pair
  assign lockSetNow = ctrlWr && !lockBit && busWdata[LOCK_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lockBit <= 1'b0;
    else if (unlockNow)  lockBit <= 1'b0;
    else if (lockSetNow) lockBit <= 1'b1;
  end

  // Strobes for the datapath
  always_comb begin
    stb.fieldWr   = ctrlWr && !lockBit;
    stb.ctrlRdSel = ctrlSel;
    stb.newProg   = busWdata[PROG_POS];
    stb.newKvIe   = busWdata[KVIE_POS];
    stb.newKtIe   = busWdata[KTIE_POS];
    stb.newOeIe   = busWdata[OEIE_POS];
  end

  // Write permits to the protected windows
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : gWin
    localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_BASE + gi);
    assign winWrStb[gi] = busWe && !lockBit && (busAddr == WIN_A);
  end

  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KS_DEAD) |=> (keyState == KS_DEAD)); // R6
  AST_DEAD_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KS_DEAD && lockBit) |=> lockBit); // R6
  AST_UNLOCK_NEEDS_KEY2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockBit) |-> $past(keyWr && (busWdata == KEY2))); // R5
  AST_LOCK_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && ctrlWr) |=> lockBit); // R3

endmodule

// File: rtl/optctl_dp.sv
module optctl_dp
  import optctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              lockBit,
  input  logic              kvErrFlag,
  input  logic              ktErrFlag,
  input  logic              optErrFlag,
  input  logic              progDone,
  output logic              progStart,
  output logic              irqOut,
  output logic [DATA_W-1:0] busRdata
);

  logic progOpt, kvIe, ktIe, oeIe;
  logic irqNext;
  logic [DATA_W-1:0] ctrlImage;

  // Field registers; an accepted write takes priority over progDone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progOpt <= 1'b0;
      kvIe    <= 1'b0;
      ktIe    <= 1'b0;
      oeIe    <= 1'b0;
    end else if (stb.fieldWr) begin
      progOpt <= stb.newProg;
      kvIe    <= stb.newKvIe;
      ktIe    <= stb.newKtIe;
      oeIe    <= stb.newOeIe;
    end else if (progDone) begin
      progOpt <= 1'b0;
    end
  end

  // Start pulse on an accepted 0-to-1 move of program-options
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progStart <= 1'b0;
    else       progStart <= stb.fieldWr && stb.newProg && !progOpt;
  end

  // Registered interrupt
  assign irqNext = (kvIe && kvErrFlag) || (ktIe && ktErrFlag) || (oeIe && optErrFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= irqNext;
  end

  // Read image
  always_comb begin
    ctrlImage           = '0;
    ctrlImage[LOCK_POS] = lockBit;
    ctrlImage[PROG_POS] = progOpt;
    ctrlImage[KVIE_POS] = kvIe;
    ctrlImage[KTIE_POS] = ktIe;
    ctrlImage[OEIE_POS] = oeIe;
  end

  assign busRdata = stb.ctrlRdSel ? ctrlImage : '0;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart); // R8
  AST_START_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> progOpt); // R8
  AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> !progStart); // R8
  AST_LOCKED_IE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> $stable({kvIe, ktIe, oeIe, progOpt}) || $fell(progOpt)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (progDone && !stb.fieldWr) |=> !progOpt); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(kvErrFlag || ktErrFlag || optErrFlag) |=> !irqOut); // R10

endmodule

// File: rtl/optctl_top.sv
module optctl_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4C0F_A9E1,
  parameter logic [DATA_W-1:0] KEY2 = 32'h7B35_D206,
  parameter int CTRL_ADDR = 0,
  parameter int KEY_ADDR = 1,
  parameter int WIN_BASE = 4,
  parameter int NUM_WIN = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               kvErrFlag,
  input  logic               ktErrFlag,
  input  logic               optErrFlag,
  input  logic               progDone,
  output logic               progStart,
  output logic [NUM_WIN-1:0] winWrStb,
  output logic               irqOut
);

  optctl_pkg::ctrlStb_t stb;
  logic lockBit;

  optctl_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2),
    .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR),
    .WIN_BASE(WIN_BASE), .NUM_WIN(NUM_WIN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .lockBit(lockBit), .stb(stb), .winWrStb(winWrStb)
  );

  optctl_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .lockBit(lockBit),
    .kvErrFlag(kvErrFlag), .ktErrFlag(ktErrFlag), .optErrFlag(optErrFlag),
    .progDone(progDone), .progStart(progStart), .irqOut(irqOut),
    .busRdata(busRdata)
  );

endmodule

// File: tb/tb_optctl_top.sv
module tb_optctl_top;

  localparam logic [31:0] K1 = 32'h4C0F_A9E1;
  localparam logic [31:0] K2 = 32'h7B35_D206;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic kvErrFlag = 1'b0, ktErrFlag = 1'b0, optErrFlag = 1'b0, progDone = 1'b0;
  logic progStart, irqOut;
  logic [2:0] winWrStb;

  int total = 0;
  int bad = 0;

  optctl_top dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .kvErrFlag(kvErrFlag),
    .ktErrFlag(ktErrFlag), .optErrFlag(optErrFlag), .progDone(progDone),
    .progStart(progStart), .winWrStb(winWrStb), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
  endtask

  function automatic logic [31:0] img(input logic lk, input logic pg, input logic [2:0] ie);
    return {25'd0, ie, 2'b00, pg, lk};
  endfunction

  logic [31:0] rv;

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // R1 reset state
    rd(4'd0, rv); chk("R1 ctrl", rv, 32'h0);
    chk("R1 irq", {31'd0, irqOut}, 32'h0);
    chk("R1 start", {31'd0, progStart}, 32'h0);
    chk("R1 win", {29'd0, winWrStb}, 32'h0);

    // R2/R8 field sweep while unlocked, unused bits forced high
    begin
      logic prevPg;
      prevPg = 1'b0;
      for (int v = 0; v < 16; v++) begin
        logic pg;
        logic [2:0] ie;
        pg = v[0]; ie = v[3:1];
        wr(4'd0, img(1'b0, pg, ie) | 32'hFFFF_FF8C & ~32'h1);
        chk("R8 start pulse", {31'd0, progStart}, {31'd0, pg && !prevPg});
        rd(4'd0, rv);
        chk("R2 readback", rv, img(1'b0, pg, ie));
        chk("R8 pulse one cycle", {31'd0, progStart}, 32'h0);
        prevPg = pg;
      end
    end

    // R9 done clears program-options
    wr(4'd0, img(1'b0, 1'b1, 3'b101));
    busAddr = 4'd2;
    progDone = 1'b1; @(negedge clk); progDone = 1'b0;
    rd(4'd0, rv); chk("R9 done clear", rv, img(1'b0, 1'b0, 3'b101));
    // R9 write wins over done
    progDone = 1'b1; wr(4'd0, img(1'b0, 1'b1, 3'b101)); progDone = 1'b0;
    rd(4'd0, rv); chk("R9 write priority", rv, img(1'b0, 1'b1, 3'b101));
    wr(4'd0, 32'h0);

    // R4/R11 unlocked address sweep (skip key register)
    for (int a = 0; a < 16; a++) begin
      if (a != 1) begin
        logic [2:0] expS;
        expS = 3'b000;
        if (a >= 4 && a <= 6) expS[a-4] = 1'b1;
        busWe = 1'b1; busAddr = 4'(a); busWdata = 32'h0;
        #1 chk("R4 strobe unlocked", {29'd0, winWrStb}, {29'd0, expS});
        @(negedge clk); busWe = 1'b0;
        rd(4'(a), rv); chk("R11 read", rv, 32'h0);
      end
    end
    rd(4'd1, rv); chk("R11 key reads zero", rv, 32'h0);

    // R7 lock set together with other fields
    wr(4'd0, img(1'b1, 1'b0, 3'b111));
    rd(4'd0, rv); chk("R7 lock with fields", rv, img(1'b1, 1'b0, 3'b111));

    // R3 locked writes ignored, R8 no pulse
    wr(4'd0, 32'h0);
    chk("R8 locked no pulse", {31'd0, progStart}, 32'h0);
    rd(4'd0, rv); chk("R3 zero write ignored", rv, img(1'b1, 1'b0, 3'b111));
    wr(4'd0, img(1'b1, 1'b1, 3'b000));
    chk("R8 locked no pulse", {31'd0, progStart}, 32'h0);
    rd(4'd0, rv); chk("R3 field write ignored", rv, img(1'b1, 1'b0, 3'b111));

    // R4 locked sweep
    for (int a = 0; a < 16; a++) begin
      if (a != 1) begin
        busWe = 1'b1; busAddr = 4'(a); busWdata = 32'h0;
        #1 chk("R4 strobe locked", {29'd0, winWrStb}, 32'h0);
        @(negedge clk); busWe = 1'b0;
      end
    end

    // R5 correct key pair
    wr(4'd1, K1);
    rd(4'd0, rv); chk("R5 still locked after KEY1", rv, img(1'b1, 1'b0, 3'b111));
    wr(4'd1, K2);
    rd(4'd0, rv); chk("R5 unlocked", rv, img(1'b0, 1'b0, 3'b111));

    // R6 four lockout causes, each from fresh reset
    for (int c = 0; c < 4; c++) begin
      doReset();
      wr(4'd0, 32'h1);
      case (c)
        0: wr(4'd1, K1 ^ 32'h1);
        1: begin wr(4'd1, K1); wr(4'd1, K2 ^ 32'h8000_0000); end
        2: wr(4'd1, K2);
        default: begin
          wr(4'd1, K1); wr(4'd1, K2);
          rd(4'd0, rv); chk("R5 unlock before repeat", rv, 32'h0);
          wr(4'd1, K1);
          wr(4'd0, 32'h1);
        end
      endcase
      wr(4'd1, K1); wr(4'd1, K2);
      rd(4'd0, rv); chk($sformatf("R6 lockout cause %0d", c), rv, 32'h1);
      wr(4'd0, 32'h0);
      rd(4'd0, rv); chk("R6 lock stays", rv, 32'h1);
    end
    doReset();
    wr(4'd0, 32'h1); wr(4'd1, K1); wr(4'd1, K2);
    rd(4'd0, rv); chk("R6 reset clears lockout", rv, 32'h0);

    // R10 interrupt sweep with latency
    for (int en = 0; en < 8; en++) begin
      logic prevExp;
      kvErrFlag = 1'b0; ktErrFlag = 1'b0; optErrFlag = 1'b0;
      wr(4'd0, img(1'b0, 1'b0, 3'(en)));
      @(negedge clk);
      prevExp = 1'b0;
      for (int fl = 0; fl < 8; fl++) begin
        logic expI;
        kvErrFlag = fl[0]; ktErrFlag = fl[1]; optErrFlag = fl[2];
        expI = |(3'(en) & 3'(fl));
        #1 chk("R10 latency", {31'd0, irqOut}, {31'd0, prevExp});
        @(negedge clk);
        chk("R10 irq value", {31'd0, irqOut}, {31'd0, expI});
        prevExp = expI;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule